// File: doc/BRIEF.md
# Grouped Timing-Error Prediction Combiner with One-Cycle Clock Gate

This block collects early-warning pulses from transition detectors placed deep inside critical timing paths. It reduces them to one prediction flag per clock cycle. The monitored paths are sorted into groups of similar criticality. Each group owns a thermometer-coded enable register, and that register decides which of the group's detector inputs may take part in the reduction. The analog delay chains and the dynamic OR tree are modelled as plain digital pulses.

A detector pulse counts only when its enable bit is set and the prediction window input is high at the sampling clock edge. While the window is low, the reduction nodes sit in precharge and report nothing. When any enabled pulse is caught inside the window, three things happen: the prediction flag is raised for the following cycle, the clock enable drops for exactly that cycle, and a per-group hit vector shows which groups produced the flag. A controller uses the hit vector to attribute errors. It adjusts the enables through a write port that takes a group index and a count of enabled detector bits.

The gate is a two-state machine:
- In `GS_OPEN` the clock enable is high.
- In `GS_HOLD` the clock enable is low and the flag is high.
- Transition T_PREDICT goes from open to hold when an enabled pulse is caught in the window.
- Transition T_REPEAT keeps the machine in hold when a new pulse is caught during a gated cycle.
- Transition T_RELEASE returns the machine to open when no pulse is caught.

Top module: `predgate_top`

## Requirements
- R1: While reset is low, and after it, every group enable register is zero (no detector enabled), `pred_flag` is 0, `clk_en` is 1 and `grp_hit` is all zeros.
- R2: A write with `en_wr`=1, group index g and count k sets group g's enable mask to its k lowest bits, where detector i of group g is `td_pulse[g*GROUP_W+i]`. A count above GROUP_W enables all bits, a count of 0 clears the group, and a group index at or above NUM_GROUPS changes no group.
- R3: A pulse on a detector input whose enable bit is clear produces no flag and no group hit.
- R4: If `pred_win` is 0 at a clock edge, that edge produces no flag and no group hit, whatever the pulses are.
- R5: If `pred_win` is 1 at a clock edge and any enabled detector pulse is 1, then `pred_flag` is 1 in the cycle that follows. In that cycle, `grp_hit[g]` is 1 exactly for the groups that had an enabled pulse.
- R6: `clk_en` is 0 in exactly the cycles in which `pred_flag` is 1. It returns to 1 by itself after a cycle whose sampling edge caught no pulse.
- R7: Hits caught at consecutive edges produce consecutive gated cycles (back-to-back gating).
- R8: Enabled pulses from several groups at the same edge produce one flag and set one `grp_hit` bit per contributing group.
- R9: A write and an evaluation at the same edge: the evaluation uses the mask held before the write, and the new mask applies from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Active-low synchronous reset |
| td_pulse | input | NUM_GROUPS*GROUP_W | Transition-detect pulses, group-major |
| pred_win | input | 1 | Prediction window, high near the end of the cycle |
| en_wr | input | 1 | Enable-register write strobe |
| en_wr_grp | input | GIDX_W | Group index for the write |
| en_wr_cnt | input | CNT_W | Number of lowest detector bits to enable |
| pred_flag | output | 1 | Predicted timing error for this cycle |
| clk_en | output | 1 | Clock-gate enable, low for a gated cycle |
| grp_hit | output | NUM_GROUPS | Groups that produced the current flag |

## Verification
Two functions can fall on the same edge: a write that changes a group's mask, and the window evaluation that reads that same mask. The bench provokes this in three ways:
- It enables a group and pulses a newly enabled input at the write edge.
- It widens one group while pulsing an input that is already enabled.
- It clears a group while pulsing one of its live inputs.

The outcome is judged on the next cycle's flag, clock enable and hit vector, which must reflect the old mask. The edge after that must reflect the new mask.

// File: rtl/predgate_pkg.sv
package predgate_pkg;
    typedef enum logic [0:0] {
        GS_OPEN = 1'b0,
        GS_HOLD = 1'b1
    } gate_state_e;
endpackage

// File: rtl/predgate_enable_bank.sv
module predgate_enable_bank #(
    parameter int NUM_GROUPS = 47,
    parameter int GROUP_W    = 3,
    parameter int GIDX_W     = 6,
    parameter int CNT_W      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [GIDX_W-1:0]             wr_grp,
    input  logic [CNT_W-1:0]              wr_cnt,
    output logic [NUM_GROUPS*GROUP_W-1:0] en_mask
);
    logic [GROUP_W-1:0] thermo;

    // Count to thermometer: bit i set when the count exceeds i.
    always_comb begin
        for (int i = 0; i < GROUP_W; i++) begin
            thermo[i] = (wr_cnt > CNT_W'(i));
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GROUP_W-1:0] mask_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else if (wr_en && (wr_grp == GIDX_W'(g))) begin
                mask_q <= thermo;
            end
        end
        assign en_mask[g*GROUP_W +: GROUP_W] = mask_q;
    end
endmodule

// File: rtl/predgate_group_or.sv
module predgate_group_or #(
    parameter int NUM_GROUPS = 47,
    parameter int GROUP_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:0] td_pulse,
    input  logic [NUM_GROUPS*GROUP_W-1:0] en_mask,
    input  logic                          pred_win,
    output logic                          hit_now,
    output logic [NUM_GROUPS-1:0]         grp_hit
);
    logic [NUM_GROUPS-1:0] hit_c;

    // Per-group evaluation; a low window models the precharge phase.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_eval
        assign hit_c[g] = pred_win &
            (|(td_pulse[g*GROUP_W +: GROUP_W] & en_mask[g*GROUP_W +: GROUP_W]));
    end

    assign hit_now = |hit_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_hit <= '0;
        end else begin
            grp_hit <= hit_c;
        end
    end
endmodule

// File: rtl/predgate_gate_fsm.sv
module predgate_gate_fsm
    import predgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_now,
    output logic pred_flag,
    output logic clk_en
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_OPEN: state_d = hit_now ? GS_HOLD : GS_OPEN;  // T_PREDICT
            GS_HOLD: state_d = hit_now ? GS_HOLD : GS_OPEN;  // T_REPEAT / T_RELEASE
            default: state_d = GS_OPEN;
        endcase
    end

    always_comb begin
        pred_flag = 1'b0;
        clk_en    = 1'b1;
        unique case (state_q)
            GS_OPEN: begin
                pred_flag = 1'b0;
                clk_en    = 1'b1;
            end
            GS_HOLD: begin
                pred_flag = 1'b1;
                clk_en    = 1'b0;
            end
            default: begin
                pred_flag = 1'b0;
                clk_en    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/predgate_top.sv
module predgate_top #(
    parameter int NUM_GROUPS = 47,
    parameter int GROUP_W    = 3,
    localparam int GIDX_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int CNT_W     = $clog2(GROUP_W + 1),
    localparam int TD_W      = NUM_GROUPS * GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TD_W-1:0]       td_pulse,
    input  logic                  pred_win,
    input  logic                  en_wr,
    input  logic [GIDX_W-1:0]     en_wr_grp,
    input  logic [CNT_W-1:0]      en_wr_cnt,
    output logic                  pred_flag,
    output logic                  clk_en,
    output logic [NUM_GROUPS-1:0] grp_hit
);
    logic [TD_W-1:0] en_mask;
    logic            hit_now;

    predgate_enable_bank #(
        .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W),
        .GIDX_W(GIDX_W), .CNT_W(CNT_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(en_wr),
        .wr_grp(en_wr_grp), .wr_cnt(en_wr_cnt), .en_mask(en_mask)
    );

    predgate_group_or #(
        .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)
    ) u_or (
        .clk(clk), .rst_n(rst_n), .td_pulse(td_pulse), .en_mask(en_mask),
        .pred_win(pred_win), .hit_now(hit_now), .grp_hit(grp_hit)
    );

    predgate_gate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit_now(hit_now),
        .pred_flag(pred_flag), .clk_en(clk_en)
    );
endmodule

// File: rtl/predgate_checker.sv
module predgate_checker #(
    parameter int NUM_GROUPS = 47,
    parameter int GROUP_W    = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_GROUPS*GROUP_W-1:0] td_pulse,
    input logic [NUM_GROUPS*GROUP_W-1:0] en_mask,
    input logic                          pred_win,
    input logic                          pred_flag,
    input logic                          clk_en,
    input logic [NUM_GROUPS-1:0]         grp_hit
);
    logic thermo_ok;
    logic any_enabled;

    always_comb begin
        thermo_ok = 1'b1;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if ((en_mask[g*GROUP_W +: GROUP_W] &
                 (en_mask[g*GROUP_W +: GROUP_W] + GROUP_W'(1))) != '0) begin
                thermo_ok = 1'b0;
            end
        end
    end

    assign any_enabled = |(td_pulse & en_mask);

    AST_MASK_THERMOMETER: assert property (@(posedge clk) disable iff (!rst_n)
        thermo_ok);  // R2
    AST_MASKED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_win && !any_enabled) |=> (grp_hit == '0));  // R3
    AST_WINDOW_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_win |=> (!pred_flag && grp_hit == '0));  // R4
    AST_GATE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (grp_hit != '0));  // R5
    AST_WINDOW_LOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_win |=> clk_en);  // R6
    AST_HIT_GATES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_win && any_enabled) |=> !clk_en);  // R7
endmodule

bind predgate_top predgate_checker #(
    .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .td_pulse(td_pulse), .en_mask(en_mask),
    .pred_win(pred_win), .pred_flag(pred_flag), .clk_en(clk_en),
    .grp_hit(grp_hit)
);

// File: tb/predgate_top_test.sv
`timescale 1ns/1ps
module predgate_top_test;
    localparam int NG  = 3;
    localparam int GW  = 5;
    localparam int NR  = 14;
    typedef logic [25:0] row_t;
    // {wr_en, grp[1:0], cnt[2:0], win, td[14:0], exp_flag, exp_hit[2:0]}
    localparam row_t ROWS [NR] = '{
        {1'b0, 2'd0, 3'd0, 1'b1, 15'h7FFF, 1'b0, 3'b000},  // 0 R3 nothing enabled
        {1'b1, 2'd0, 3'd2, 1'b1, 15'h0001, 1'b0, 3'b000},  // 1 R9 write g0 uses old mask
        {1'b0, 2'd0, 3'd0, 1'b1, 15'h0001, 1'b1, 3'b001},  // 2 R5 g0 bit0 hit
        {1'b0, 2'd0, 3'd0, 1'b1, 15'h0004, 1'b0, 3'b000},  // 3 R6 release, bit2 masked
        {1'b0, 2'd0, 3'd0, 1'b0, 15'h0002, 1'b0, 3'b000},  // 4 R4 window low
        {1'b1, 2'd1, 3'd7, 1'b1, 15'h0002, 1'b1, 3'b001},  // 5 R9 write g1, old g0 hit
        {1'b0, 2'd0, 3'd0, 1'b1, 15'h0200, 1'b1, 3'b010},  // 6 R7 back-to-back, saturated g1
        {1'b1, 2'd3, 3'd5, 1'b1, 15'h0021, 1'b1, 3'b011},  // 7 R8 two groups
        {1'b1, 2'd2, 3'd1, 1'b1, 15'h0400, 1'b0, 3'b000},  // 8 R9 write g2 not yet live
        {1'b0, 2'd0, 3'd0, 1'b1, 15'h7C00, 1'b1, 3'b100},  // 9 R2 only g2 bit0
        {1'b1, 2'd1, 3'd0, 1'b1, 15'h0200, 1'b1, 3'b010},  // 10 R9 clear g1, old live
        {1'b0, 2'd0, 3'd0, 1'b1, 15'h03E0, 1'b0, 3'b000},  // 11 R2 g1 cleared
        {1'b0, 2'd0, 3'd0, 1'b1, 15'h0006, 1'b1, 3'b001},  // 12 R2 bad index left g0
        {1'b0, 2'd0, 3'd0, 1'b0, 15'h7FFF, 1'b0, 3'b000}   // 13 R4 window low
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NG*GW-1:0] td_pulse = '0;
    logic           pred_win = 1'b0;
    logic           en_wr = 1'b0;
    logic [1:0]     en_wr_grp = '0;
    logic [2:0]     en_wr_cnt = '0;
    logic           pred_flag;
    logic           clk_en;
    logic [NG-1:0]  grp_hit;
    int             n_run = 0;
    int             n_fail = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;

    predgate_top #(.NUM_GROUPS(NG), .GROUP_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .td_pulse(td_pulse), .pred_win(pred_win),
        .en_wr(en_wr), .en_wr_grp(en_wr_grp), .en_wr_cnt(en_wr_cnt),
        .pred_flag(pred_flag), .clk_en(clk_en), .grp_hit(grp_hit)
    );

    function automatic string tag_of(int i);
        case (i)
            0:            return "R3";
            1, 5, 8, 10:  return "R9";
            2:            return "R5";
            3:            return "R6";
            4, 13:        return "R4";
            6:            return "R7";
            7:            return "R8";
            default:      return "R2";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(string tag, logic ef, logic [NG-1:0] eh);
        chk(tag, "pred_flag", {7'd0, pred_flag}, {7'd0, ef});
        chk(tag, "clk_en", {7'd0, clk_en}, {7'd0, ~ef});
        chk(tag, "grp_hit", {5'd0, grp_hit}, {5'd0, eh});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1", 1'b0, '0);  // during reset
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 1'b0, '0);  // after release

        for (int i = 0; i < NR; i++) begin
            en_wr     = ROWS[i][25];
            en_wr_grp = ROWS[i][24:23];
            en_wr_cnt = ROWS[i][22:20];
            pred_win  = ROWS[i][19];
            td_pulse  = ROWS[i][18:4];
            @(negedge clk);
            chk_all(tag_of(i), ROWS[i][3], ROWS[i][2:0]);
        end
        en_wr = 1'b0;

        // R1: reset in mid-run with a hit pending clears flag and masks
        pred_win = 1'b1;
        td_pulse = 15'h0001;
        rst_n    = 1'b0;
        @(negedge clk);
        chk_all("R1", 1'b0, '0);
        rst_n    = 1'b1;
        td_pulse = '1;
        @(negedge clk);
        chk_all("R1", 1'b0, '0);  // masks were cleared

        // R6: gate releases after a single hit
        en_wr = 1'b1; en_wr_grp = 2'd2; en_wr_cnt = 3'd3;
        pred_win = 1'b0; td_pulse = '0;
        @(negedge clk);
        en_wr = 1'b0; pred_win = 1'b1; td_pulse = 15'h1000;
        @(negedge clk);
        chk_all("R6", 1'b1, 3'b100);
        td_pulse = '0;
        @(negedge clk);
        chk_all("R6", 1'b0, '0);

        finish_run();
    end
endmodule